// File: doc/BRIEF.md
# Byte-Serial Lockstep Array Element

This block is one processing element of a lockstep array. It does no instruction decoding of its own. A controller broadcasts the same micro-instruction to every element. Each micro-instruction carries an opcode, a destination address, two source addresses, an immediate byte and a length code. The element works memory to memory. It reads operand bytes from its own local RAM into two 8-bit working registers. It passes them through an 8-bit ALU and writes the result byte back. The least significant byte is handled first, and the carry or borrow is held in a register from one byte to the next. Every address comes from the micro-instruction. A value read from memory never becomes an address.

The local RAM holds 384 bytes in two regions. A 256-byte main region sits at addresses 0 to 255. Four 32-byte partitions follow at addresses 256 to 383, and all of them are addressed flatly. Each element keeps an enable flag, which compare instructions set. While the flag is clear, the element still steps through each instruction in lockstep with the rest of the array, but it does not write memory. Each RAM write is visible on a write-observation output. A done pulse marks the step that handles the final byte.

Top module: `simd_pe`

## Requirements
- R1: After reset, busy, done and mem_we are 0 and en_flag is 1.
- R2: A micro-instruction is accepted when uop_valid is 1 and busy is 0. The length code uop_len selects the operand size: 0 gives 1 byte, 1 gives 2, 2 gives 4 and 3 gives 8. Byte i of an operand lives at its base address plus i, and byte 0 is the least significant.
- R3: Opcode 1 (add) writes dst = a + b. The carry passes from each byte to the next, and the result is truncated to the operand size.
- R4: Opcode 2 (subtract) writes dst = a - b. The borrow passes from each byte to the next, and the result is truncated to the operand size.
- R5: Opcodes 3, 4 and 5 write the bitwise AND, OR and XOR of a and b, byte by byte.
- R6: Opcode 6 copies a to dst. Opcode 7 writes the bitwise inverse of a. Opcode 8 writes uop_imm into every byte of dst.
- R7: Let N be the clock edge that accepts the micro-instruction. Two-source opcodes (1 to 5, 9 and 10) take 3 cycles per byte, and byte i is written in the cycle that ends at edge N+3+3i. All other opcodes take 2 cycles per byte, and byte i is written in the cycle that ends at edge N+2+2i.
- R8: done is 1 for exactly one cycle per instruction: the write step of the last byte. busy drops at the edge that ends that cycle.
- R9: Opcode 9 sets en_flag to 1 if all bytes of a and b are equal, and to 0 otherwise. Opcode 10 sets en_flag to 1 exactly when a < b as unsigned multi-byte numbers. Opcode 11 sets en_flag to 1. These three opcodes write no memory.
- R10: While en_flag is 0, writing opcodes make no memory write and leave memory unchanged. They still take the same cycles and still raise done.
- R11: uop_valid is ignored while busy is 1. Opcode 0 and opcodes 12 to 15 are ignored and do not set busy.
- R12: Addresses 0 to 383 are all readable and writable, including transfers between the main region and the partitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uop_valid | input | 1 | A broadcast micro-instruction is present |
| uop_op | input | 4 | Opcode |
| uop_len | input | 2 | Operand length code (1, 2, 4 or 8 bytes) |
| uop_dst | input | 9 | Destination base address |
| uop_srca | input | 9 | First source base address |
| uop_srcb | input | 9 | Second source base address |
| uop_imm | input | 8 | Immediate byte |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Write step of the last byte |
| en_flag | output | 1 | Per-element enable flag |
| mem_we | output | 1 | A RAM byte is written at the next edge |
| mem_waddr | output | 9 | Address of that write |
| mem_wdata | output | 8 | Data of that write |

## Verification
Every result of this block is due at a fixed offset from the accepting edge N. A write or a done step falls in the cycle that ends at N+3+3i for two-source byte i, or at N+2+2i for every other opcode. At the moment it issues an instruction, the driver computes each write address, its data and that exact cycle. It pushes them, together with the done bit, to a scoreboard. The monitor samples on the falling edge, so each expected item must match in content and in cycle, and any write or done with no item waiting is reported. The flag is checked only once busy has dropped, which is after the edge where a compare commits.

// File: rtl/simd_pe_pkg.sv
package simd_pe_pkg;

   typedef enum logic [3:0] {
      OP_NOP   = 4'd0,
      OP_ADD   = 4'd1,
      OP_SUB   = 4'd2,
      OP_AND   = 4'd3,
      OP_OR    = 4'd4,
      OP_XOR   = 4'd5,
      OP_MOV   = 4'd6,
      OP_NOT   = 4'd7,
      OP_LDI   = 4'd8,
      OP_CEQ   = 4'd9,
      OP_CLT   = 4'd10,
      OP_SETEN = 4'd11
   } pe_op_e;

   typedef enum logic [1:0] {
      PH_RDA = 2'd0,
      PH_RDB = 2'd1,
      PH_EX  = 2'd2
   } pe_phase_e;

   function automatic logic op_known(input logic [3:0] code);
      return (code != 4'd0) && (code <= 4'd11);
   endfunction

   function automatic logic op_two_src(input pe_op_e op);
      return op inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_CEQ, OP_CLT};
   endfunction

   function automatic logic op_writes(input pe_op_e op);
      return !(op inside {OP_CEQ, OP_CLT, OP_SETEN});
   endfunction

endpackage

// File: rtl/pe_ram.sv
module pe_ram #(
   parameter int DATA_W     = 8,
   parameter int MAIN_BYTES = 256,
   parameter int PART_CNT   = 4,
   parameter int PART_BYTES = 32,
   parameter int ADDR_W     = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int MAIN_AW = $clog2(MAIN_BYTES);
   localparam int PART_AW = $clog2(PART_BYTES);

   logic [DATA_W-1:0] main_mem [MAIN_BYTES];
   logic [DATA_W-1:0] part_rd  [PART_CNT];
   logic [PART_CNT-1:0] part_hit;
   logic main_rhit, main_whit;

   assign main_rhit = raddr < ADDR_W'(MAIN_BYTES);
   assign main_whit = waddr < ADDR_W'(MAIN_BYTES);

   always_ff @(posedge clk) begin
      if (we && main_whit) main_mem[waddr[MAIN_AW-1:0]] <= wdata;
   end

   // one bank per I/O partition, stacked above the main region
   for (genvar p = 0; p < PART_CNT; p++) begin : g_part
      localparam int BASE = MAIN_BYTES + p * PART_BYTES;
      logic [DATA_W-1:0] bank [PART_BYTES];
      logic whit;
      assign whit        = (waddr >= ADDR_W'(BASE)) && (waddr < ADDR_W'(BASE + PART_BYTES));
      assign part_hit[p] = (raddr >= ADDR_W'(BASE)) && (raddr < ADDR_W'(BASE + PART_BYTES));
      assign part_rd[p]  = bank[raddr[PART_AW-1:0]];
      always_ff @(posedge clk) begin
         if (we && whit) bank[waddr[PART_AW-1:0]] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (main_rhit) rdata = main_mem[raddr[MAIN_AW-1:0]];
      for (int p = 0; p < PART_CNT; p++) begin
         if (part_hit[p]) rdata = part_rd[p];
      end
   end
endmodule

// File: rtl/pe_alu.sv
module pe_alu
   import simd_pe_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  pe_op_e            op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] imm,
   input  logic              cin,
   output logic [DATA_W-1:0] y,
   output logic              cout
);
   logic [DATA_W:0] sum, diff;

   assign sum  = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
   assign diff = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};

   always_comb begin
      y    = a;
      cout = 1'b0;
      case (op)
         OP_ADD:         begin y = sum[DATA_W-1:0];  cout = sum[DATA_W];  end
         OP_SUB, OP_CLT: begin y = diff[DATA_W-1:0]; cout = diff[DATA_W]; end
         OP_AND:         y = a & b;
         OP_OR:          y = a | b;
         OP_XOR:         y = a ^ b;
         OP_NOT:         y = ~a;
         OP_LDI:         y = imm;
         default:        y = a;
      endcase
   end
endmodule

// File: rtl/pe_seq.sv
module pe_seq
   import simd_pe_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 9,
   parameter int MAX_BYTES  = 8,
   parameter int LEN_CODE_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  uop_valid,
   input  logic [3:0]            uop_op,
   input  logic [LEN_CODE_W-1:0] uop_len,
   input  logic [ADDR_W-1:0]     uop_dst,
   input  logic [ADDR_W-1:0]     uop_srca,
   input  logic [ADDR_W-1:0]     uop_srcb,
   input  logic [DATA_W-1:0]     uop_imm,
   output logic [ADDR_W-1:0]     ram_raddr,
   input  logic [DATA_W-1:0]     ram_rdata,
   output logic                  ram_we,
   output logic [ADDR_W-1:0]     ram_waddr,
   output pe_op_e                alu_op,
   output logic [DATA_W-1:0]     alu_a,
   output logic [DATA_W-1:0]     alu_b,
   output logic [DATA_W-1:0]     alu_imm,
   output logic                  alu_cin,
   input  logic                  alu_cout,
   output logic                  busy,
   output logic                  done,
   output logic                  en_flag
);
   localparam int IDX_W = $clog2(MAX_BYTES);

   pe_phase_e         ph_q;
   pe_op_e            op_q;
   logic [IDX_W-1:0]  idx_q, last_q;
   logic [ADDR_W-1:0] dst_q, srca_q, srcb_q;
   logic [DATA_W-1:0] imm_q, ra_q, rb_q;
   logic              busy_q, carry_q, eq_q, flag_q;
   logic              accept, in_ex, last_step, eq_all;

   assign accept    = uop_valid && !busy_q && op_known(uop_op);
   assign in_ex     = busy_q && (ph_q == PH_EX);
   assign last_step = in_ex && (idx_q == last_q);
   assign eq_all    = eq_q && (ra_q == rb_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         ph_q    <= PH_RDA;
         op_q    <= OP_NOP;
         idx_q   <= '0;
         last_q  <= '0;
         dst_q   <= '0;
         srca_q  <= '0;
         srcb_q  <= '0;
         imm_q   <= '0;
         ra_q    <= '0;
         rb_q    <= '0;
         carry_q <= 1'b0;
         eq_q    <= 1'b1;
         flag_q  <= 1'b1;
      end else if (accept) begin
         busy_q  <= 1'b1;
         ph_q    <= PH_RDA;
         op_q    <= pe_op_e'(uop_op);
         idx_q   <= '0;
         last_q  <= IDX_W'((1 << uop_len) - 1);
         dst_q   <= uop_dst;
         srca_q  <= uop_srca;
         srcb_q  <= uop_srcb;
         imm_q   <= uop_imm;
         carry_q <= 1'b0;
         eq_q    <= 1'b1;
      end else if (busy_q) begin
         case (ph_q)
            PH_RDA: begin
               ra_q <= ram_rdata;
               ph_q <= op_two_src(op_q) ? PH_RDB : PH_EX;
            end
            PH_RDB: begin
               rb_q <= ram_rdata;
               ph_q <= PH_EX;
            end
            default: begin
               carry_q <= alu_cout;
               eq_q    <= eq_all;
               ph_q    <= PH_RDA;
               if (idx_q == last_q) begin
                  busy_q <= 1'b0;
                  if (op_q == OP_CEQ)   flag_q <= eq_all;
                  if (op_q == OP_CLT)   flag_q <= alu_cout;
                  if (op_q == OP_SETEN) flag_q <= 1'b1;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign ram_raddr = ((ph_q == PH_RDB) ? srcb_q : srca_q) + ADDR_W'(idx_q);
   assign ram_waddr = dst_q + ADDR_W'(idx_q);
   assign ram_we    = in_ex && op_writes(op_q) && flag_q;
   assign alu_op    = op_q;
   assign alu_a     = ra_q;
   assign alu_b     = rb_q;
   assign alu_imm   = imm_q;
   assign alu_cin   = carry_q;
   assign busy      = busy_q;
   assign done      = last_step;
   assign en_flag   = flag_q;
endmodule

// File: rtl/simd_pe.sv
module simd_pe
   import simd_pe_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int MAIN_BYTES = 256,
   parameter int PART_CNT   = 4,
   parameter int PART_BYTES = 32,
   parameter int MAX_BYTES  = 8,
   parameter int ADDR_W     = $clog2(MAIN_BYTES + PART_CNT * PART_BYTES),
   parameter int LEN_CODE_W = $clog2($clog2(MAX_BYTES) + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  uop_valid,
   input  logic [3:0]            uop_op,
   input  logic [LEN_CODE_W-1:0] uop_len,
   input  logic [ADDR_W-1:0]     uop_dst,
   input  logic [ADDR_W-1:0]     uop_srca,
   input  logic [ADDR_W-1:0]     uop_srcb,
   input  logic [DATA_W-1:0]     uop_imm,
   output logic                  busy,
   output logic                  done,
   output logic                  en_flag,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_waddr,
   output logic [DATA_W-1:0]     mem_wdata
);
   localparam int MEM_BYTES = MAIN_BYTES + PART_CNT * PART_BYTES;

   if ((MAIN_BYTES & (MAIN_BYTES - 1)) != 0 || (PART_BYTES & (PART_BYTES - 1)) != 0) begin : g_bad_pow2
      $error("simd_pe: region sizes must be powers of two");
   end
   if (MAIN_BYTES < PART_BYTES || MAX_BYTES < 2 || (MAX_BYTES & (MAX_BYTES - 1)) != 0) begin : g_bad_size
      $error("simd_pe: bad MAIN_BYTES/PART_BYTES/MAX_BYTES combination");
   end
   if ((1 << ADDR_W) < MEM_BYTES) begin : g_bad_addr
      $error("simd_pe: ADDR_W too narrow for local memory");
   end

   logic [ADDR_W-1:0] ram_raddr;
   logic [DATA_W-1:0] ram_rdata, alu_a, alu_b, alu_imm, alu_y;
   logic              alu_cin, alu_cout;
   pe_op_e            alu_op;

   pe_seq #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES), .LEN_CODE_W(LEN_CODE_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .uop_valid(uop_valid), .uop_op(uop_op), .uop_len(uop_len),
      .uop_dst(uop_dst), .uop_srca(uop_srca), .uop_srcb(uop_srcb), .uop_imm(uop_imm),
      .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
      .ram_we(mem_we), .ram_waddr(mem_waddr),
      .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b), .alu_imm(alu_imm),
      .alu_cin(alu_cin), .alu_cout(alu_cout),
      .busy(busy), .done(done), .en_flag(en_flag)
   );

   pe_alu #(.DATA_W(DATA_W)) u_alu (
      .op(alu_op), .a(alu_a), .b(alu_b), .imm(alu_imm), .cin(alu_cin),
      .y(alu_y), .cout(alu_cout)
   );

   pe_ram #(
      .DATA_W(DATA_W), .MAIN_BYTES(MAIN_BYTES), .PART_CNT(PART_CNT),
      .PART_BYTES(PART_BYTES), .ADDR_W(ADDR_W)
   ) u_ram (
      .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(alu_y),
      .raddr(ram_raddr), .rdata(ram_rdata)
   );

   assign mem_wdata = alu_y;
endmodule

// File: rtl/simd_pe_chk.sv
module simd_pe_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic en_flag,
   input logic mem_we
);
   // R10: a memory write only ever happens with the enable flag set
   p_we_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> en_flag);

   // R11: an idle element neither writes nor signals completion
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_we && !done));

   // R8: done only appears while an instruction runs, and ends it
   p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
   p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!busy && !done));

   // R11: once started, an instruction runs on until its done step
   p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   // R9: the flag only moves at the end of an instruction
   p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(en_flag));
endmodule

bind simd_pe simd_pe_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
   .en_flag(en_flag), .mem_we(mem_we)
);

// File: tb/simd_pe_tb.sv
module simd_pe_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       uop_valid = 1'b0;
   logic [3:0] uop_op = '0;
   logic [1:0] uop_len = '0;
   logic [8:0] uop_dst = '0, uop_srca = '0, uop_srcb = '0;
   logic [7:0] uop_imm = '0;
   logic       busy, done, en_flag, mem_we;
   logic [8:0] mem_waddr;
   logic [7:0] mem_wdata;

   always #5 clk = ~clk;

   simd_pe u_dut (
      .clk(clk), .rst_n(rst_n), .uop_valid(uop_valid), .uop_op(uop_op),
      .uop_len(uop_len), .uop_dst(uop_dst), .uop_srca(uop_srca),
      .uop_srcb(uop_srcb), .uop_imm(uop_imm), .busy(busy), .done(done),
      .en_flag(en_flag), .mem_we(mem_we), .mem_waddr(mem_waddr),
      .mem_wdata(mem_wdata)
   );

   typedef struct {
      int    due;
      bit    we;
      int    addr;
      int    data;
      bit    dn;
      string tag;
   } exp_t;

   exp_t  sb[$];
   int    cyc = 0;
   int    checks = 0;
   int    errors = 0;
   int    model [384];
   bit    mflag = 1'b1;
   bit    finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // monitor: every write or done step must match the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n && (mem_we || done)) begin
         if (sb.size() == 0) begin
            check(1'b0, "R10 R11", "unexpected write/done at cycle", cyc, -1);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(cyc == e.due && mem_we == e.we && done == e.dn &&
                  (!e.we || (int'(mem_waddr) == e.addr && int'(mem_wdata) == e.data)),
                  e.tag, $sformatf("cyc/we/done/addr/data %0d/%0d/%0d/%0d", e.due, e.we, e.dn, e.addr),
                  (cyc << 20) | (int'(mem_waddr) << 8) | int'(mem_wdata),
                  (e.due << 20) | (e.addr << 8) | e.data);
         end
      end
   end

   // driver: issues one micro-instruction and predicts every step it causes
   task automatic issue(input int op, input int lc, input int d, input int a,
                        input int b, input int imm, input string tag);
      int  n, per, nb, carry, va, vb, s, y;
      bit  eq, wr;
      exp_t e;
      while (busy) @(negedge clk);
      uop_valid = 1'b1; uop_op = 4'(op); uop_len = 2'(lc);
      uop_dst = 9'(d); uop_srca = 9'(a); uop_srcb = 9'(b); uop_imm = 8'(imm);
      n   = cyc + 1;
      per = (op inside {1, 2, 3, 4, 5, 9, 10}) ? 3 : 2;
      nb  = 1 << lc;
      carry = 0; eq = 1'b1;
      wr  = !(op inside {9, 10, 11}) && mflag;
      for (int i = 0; i < nb; i++) begin
         va = model[a + i]; vb = model[b + i]; y = va;
         case (op)
            1: begin s = va + vb + carry; y = s & 255; carry = s >> 8; end
            2, 10: begin s = va - vb - carry; y = s & 255; carry = (s < 0) ? 1 : 0; end
            3: y = va & vb;
            4: y = va | vb;
            5: y = va ^ vb;
            7: y = (~va) & 255;
            8: y = imm & 255;
            default: y = va;
         endcase
         if (va != vb) eq = 1'b0;
         if (wr || i == nb - 1) begin
            e.due = n + per - 1 + per * i; e.we = wr; e.addr = d + i;
            e.data = y; e.dn = (i == nb - 1); e.tag = tag;
            sb.push_back(e);
         end
         if (wr) model[d + i] = y;
      end
      if (op == 9)  mflag = eq;
      if (op == 10) mflag = carry[0];
      if (op == 11) mflag = 1'b1;
      @(negedge clk);
      uop_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic check_flag(input string tag);
      wait_idle();
      check(en_flag == mflag, tag, "en_flag", en_flag, mflag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 384; i++) model[i] = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(busy == 1'b0, "R1", "busy", busy, 0);
      check(done == 1'b0, "R1", "done", done, 0);
      check(mem_we == 1'b0, "R1", "mem_we", mem_we, 0);
      check(en_flag == 1'b1, "R1", "en_flag", en_flag, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R6 R2: fill with distinct single bytes and multi-byte immediates
      for (int i = 0; i < 16; i++) issue(8, 0, i, 0, 0, (i * 37 + 11) & 255, "R6 R2 R7 R8");
      issue(8, 3, 16, 0, 0, 255, "R6 R2");
      issue(8, 3, 24, 0, 0, 0, "R6 R2");
      issue(8, 0, 24, 0, 0, 1, "R6");
      // R3 carry ripples through all eight bytes, result wraps to zero
      issue(1, 3, 40, 16, 24, 0, "R3 R2 R7 R8");
      issue(1, 1, 50, 0, 2, 0, "R3");
      issue(1, 2, 54, 4, 8, 0, "R3");
      // R4 borrow chain
      issue(2, 2, 60, 24, 16, 0, "R4 R7");
      issue(2, 3, 64, 8, 0, 0, "R4");
      // R5 bitwise
      issue(3, 1, 72, 0, 4, 0, "R5");
      issue(4, 1, 74, 0, 4, 0, "R5");
      issue(5, 2, 76, 3, 9, 0, "R5");
      // R6 move and invert, R12 partitions
      issue(8, 2, 300, 0, 0, 90, "R6 R12");
      issue(6, 2, 80, 300, 0, 0, "R6 R12 R7");
      issue(6, 3, 376, 0, 0, 0, "R6 R12");
      issue(7, 3, 260, 376, 0, 0, "R6 R12");
      issue(6, 3, 84, 260, 0, 0, "R12");
      issue(6, 0, 383, 5, 0, 0, "R12");
      issue(7, 0, 100, 383, 0, 0, "R12 R6");

      // R11 uop_valid while busy is ignored
      issue(1, 3, 110, 0, 8, 0, "R11 R3");
      uop_valid = 1'b1; uop_op = 4'd8; uop_len = 2'd3; uop_dst = 9'd0; uop_imm = 8'hEE;
      repeat (2) @(negedge clk);
      uop_valid = 1'b0;
      issue(6, 3, 120, 0, 0, 0, "R11");
      // R11 NOP and undefined opcodes do not start
      wait_idle();
      uop_valid = 1'b1; uop_op = 4'd0;
      @(negedge clk);
      uop_op = 4'd14;
      @(negedge clk);
      check(busy == 1'b0, "R11", "busy after nop/undefined", busy, 0);
      uop_valid = 1'b0;
      @(negedge clk);

      // R9 compares
      issue(9, 2, 0, 0, 120, 0, "R9");
      check_flag("R9 equal");
      issue(9, 2, 0, 0, 4, 0, "R9");
      check_flag("R9 unequal");
      issue(11, 0, 0, 0, 0, 0, "R9");
      check_flag("R9 seten");
      issue(8, 0, 130, 0, 0, 200, "R6");
      issue(8, 0, 131, 0, 0, 1, "R6");
      issue(8, 0, 132, 0, 0, 5, "R6");
      issue(8, 0, 133, 0, 0, 2, "R6");
      issue(10, 1, 0, 130, 132, 0, "R9");
      check_flag("R9 less true");
      issue(10, 1, 0, 132, 130, 0, "R9");
      check_flag("R9 less false");

      // R10 flag clear: same cycles and done, no write
      issue(8, 2, 140, 0, 0, 51, "R6");
      issue(9, 0, 0, 0, 1, 0, "R9");
      check_flag("R9 clear");
      issue(1, 2, 140, 0, 8, 0, "R10");
      issue(8, 3, 140, 0, 0, 7, "R10");
      issue(11, 0, 0, 0, 0, 0, "R10");
      check_flag("R10 restore");
      issue(6, 2, 150, 140, 0, 0, "R10");

      wait_idle();
      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R7 R8", "scoreboard leftover", sb.size(), 0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule